// File: doc/BRIEF.md
# Banked Register File with Hardware Stack

This block is the internal data store of a small 8-bit controller core. It holds 128 bytes of working RAM. Three views share that RAM. Whole bytes can be reached by direct address. Eight working registers R0 to R7 are relocated into one of four banks by a 2-bit bank select. A hardware stack, steered by an 8-bit stack pointer, grows upward through the same bytes. A sixteen-byte region starting at 20H can also be set, cleared and read one bit at a time.

Each clock cycle carries at most one operation, chosen by a 4-bit operation code. Every read result is registered and appears on the output one cycle after the request. Stack operations that would leave the RAM are refused and raise an error flag that stays set until reset.

Top module: `regbank_stack_ram`

## Requirements
- R1: After reset the stack pointer reads 07H, the bank select reads 0, the error flag is 0, and both read outputs are 0.
- R2: Operation code 2 writes `wdata_i` to byte `addr_i`, and code 1 reads byte `addr_i`. Any address from 00H to 7FH can be used. The read byte appears on `rdata_o` one cycle after the request.
- R3: Code 11 loads the bank select from `wdata_i[1:0]`, with bit 1 as the upper select bit. Code 4 writes register `reg_i` and code 3 reads it. Both use the RAM byte at bank × 8 + `reg_i`.
- R4: Code 5 (push) first raises the stack pointer by one and then writes `wdata_i` at the new pointer value.
- R5: Code 6 (pop) returns the byte at the stack pointer on `rdata_o` one cycle later, and lowers the pointer by one.
- R6: Code 7 loads the stack pointer with any 8-bit `wdata_i`. A later push then writes at that value plus one.
- R7: Code 8 sets and code 9 clears the bit at bit address `addr_i`, which lies in byte 20H + `addr_i`[6:3] at bit position `addr_i`[2:0]. The other seven bits of that byte keep their values.
- R8: Code 10 returns the bit at bit address `addr_i` on `rbit_o` one cycle later. The same byte and bit mapping as R7 applies.
- R9: A push while the pointer is 7FH or above is refused. So is a pop while the pointer is 00H or above 7FH. A refused operation sets the error flag, which stays set until reset. It leaves the pointer and all RAM bytes unchanged and does not alter `rdata_o`.
- R10: Code 0 and codes 12 to 15 change nothing: neither RAM, pointer, bank select nor error flag.
- R11: `rdata_o` changes only on codes 1, 3 and an accepted pop. `rbit_o` changes only on code 10. Otherwise both hold their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code for this cycle |
| addr_i | input | 7 | Byte address (codes 1, 2) or bit address (codes 8, 9, 10) |
| reg_i | input | 3 | Working register number for codes 3, 4 |
| wdata_i | input | 8 | Write data, pushed byte, pointer value or bank select |
| rdata_o | output | 8 | Registered read byte |
| rbit_o | output | 1 | Registered read bit |
| sp_o | output | 8 | Current stack pointer |
| bank_o | output | 2 | Current bank select |
| err_o | output | 1 | Sticky stack error flag |

## Verification
The bench builds the block with its default parameters: a 128-byte RAM, 8-bit data, eight registers per bank, and a sixteen-byte bit window at 20H. With these values the whole address space can be filled and read back. All four banks, including the top register 1FH, are in reach. The pointer can be driven to both ends of the RAM, so the refused push at 7FH and the refused pop at 00H are exercised. The first and last bit addresses of the window, 00H and 7FH, are reachable as well.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  localparam int RAM_AW   = 7;
  localparam int DATA_W   = 8;
  localparam int REG_W    = 3;
  localparam int BANK_W   = 2;
  localparam int SP_W     = 8;
  localparam int OP_W     = 4;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE = 4'd0,
    OP_RD   = 4'd1,
    OP_WR   = 4'd2,
    OP_RRD  = 4'd3,
    OP_RWR  = 4'd4,
    OP_PUSH = 4'd5,
    OP_POP  = 4'd6,
    OP_SPLD = 4'd7,
    OP_BSET = 4'd8,
    OP_BCLR = 4'd9,
    OP_BRD  = 4'd10,
    OP_BANK = 4'd11
  } op_e;

  // Working register location: bank times registers-per-bank plus register number.
  function automatic logic [RAM_AW-1:0] reg_location(
    input logic [BANK_W-1:0] bank,
    input logic [REG_W-1:0]  rnum
  );
    logic [RAM_AW-1:0] base;
    base = RAM_AW'(bank) * RAM_AW'(1 << REG_W);
    return base + RAM_AW'(rnum);
  endfunction

  // Byte that holds a bit address inside the bit window.
  function automatic logic [RAM_AW-1:0] bit_byte(
    input logic [RAM_AW-1:0] base,
    input logic [RAM_AW-1:0] bitaddr
  );
    return base + (bitaddr >> 3);
  endfunction

  // Bit position inside that byte.
  function automatic logic [2:0] bit_pos(input logic [RAM_AW-1:0] bitaddr);
    return bitaddr[2:0];
  endfunction

endpackage

// File: rtl/rbs_bank_sel.sv
module rbs_bank_sel #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] value,
  output logic [BANK_W-1:0] bank
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank <= '0;
    else if (load) bank <= value;
  end

endmodule

// File: rtl/rbs_stack_ctl.sv
module rbs_stack_ctl #(
  parameter int SP_W    = 8,
  parameter int RAM_AW  = 7,
  parameter int SP_INIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic            load_req,
  input  logic [SP_W-1:0] load_val,
  output logic [SP_W-1:0] sp,
  output logic            push_fire,
  output logic            pop_fire,
  output logic            fault_evt,
  output logic            err
);

  localparam logic [SP_W-1:0] TOP_ADDR = SP_W'((1 << RAM_AW) - 1);
  localparam logic [SP_W-1:0] INIT_VAL = SP_W'(SP_INIT);

  logic push_room;
  logic pop_valid;

  assign push_room = (sp < TOP_ADDR);
  assign pop_valid = (sp != '0) && (sp <= TOP_ADDR);

  assign push_fire = push_req && push_room;
  assign pop_fire  = pop_req && pop_valid;
  assign fault_evt = (push_req && !push_room) || (pop_req && !pop_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sp <= INIT_VAL;
    else if (load_req)  sp <= load_val;
    else if (push_fire) sp <= sp + SP_W'(1);
    else if (pop_fire)  sp <= sp - SP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err <= 1'b0;
    else if (fault_evt) err <= 1'b1;
  end

endmodule

// File: rtl/rbs_ram.sv
module rbs_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          bit_wr,
  input  logic          bit_rd,
  input  logic [AW-1:0] bit_addr,
  input  logic [2:0]    bit_idx,
  input  logic          bit_val,
  output logic [DW-1:0] rd_data,
  output logic          rd_bit
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] bit_target;
  logic [DW-1:0] bit_merged;

  assign bit_target = mem[bit_addr];

  always_comb begin
    bit_merged = bit_target;
    bit_merged[bit_idx] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (wr_en)       mem[wr_addr]  <= wr_data;
    else if (bit_wr) mem[bit_addr] <= bit_merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_bit <= 1'b0;
    else if (bit_rd) rd_bit <= bit_target[bit_idx];
  end

endmodule

// File: rtl/regbank_stack_ram.sv
module regbank_stack_ram
  import rbs_pkg::*;
#(
  parameter int AW       = RAM_AW,
  parameter int DW       = DATA_W,
  parameter int RW       = REG_W,
  parameter int BW       = BANK_W,
  parameter int SPW      = SP_W,
  parameter int SP_INIT  = 7,
  parameter int BIT_BASE = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     op_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [RW-1:0]  reg_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           rbit_o,
  output logic [SPW-1:0] sp_o,
  output logic [BW-1:0]  bank_o,
  output logic           err_o
);

  localparam logic [AW-1:0] WIN_BASE = AW'(BIT_BASE);

  op_e op;
  assign op = op_e'(op_i);

  // Named internal events for the checker
  logic push_fire;
  logic pop_fire;
  logic fault_evt;

  logic          wr_en, rd_en, bit_wr, bit_rd, bit_val;
  logic [AW-1:0] wr_addr, rd_addr, bit_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] reg_addr;
  logic [AW-1:0] push_addr;
  logic [AW-1:0] pop_addr;

  assign reg_addr  = reg_location(bank_o, reg_i);
  assign push_addr = sp_o[AW-1:0] + AW'(1);
  assign pop_addr  = sp_o[AW-1:0];
  assign bit_addr  = bit_byte(WIN_BASE, addr_i);

  rbs_bank_sel #(.BANK_W(BW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (op == OP_BANK),
    .value (wdata_i[BW-1:0]),
    .bank  (bank_o)
  );

  rbs_stack_ctl #(.SP_W(SPW), .RAM_AW(AW), .SP_INIT(SP_INIT)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (op == OP_PUSH),
    .pop_req   (op == OP_POP),
    .load_req  (op == OP_SPLD),
    .load_val  (wdata_i[SPW-1:0]),
    .sp        (sp_o),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .fault_evt (fault_evt),
    .err       (err_o)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = addr_i;
    wr_data = wdata_i;
    rd_en   = 1'b0;
    rd_addr = addr_i;
    bit_wr  = 1'b0;
    bit_rd  = 1'b0;
    bit_val = 1'b0;
    unique case (op)
      OP_RD:   rd_en = 1'b1;
      OP_WR:   wr_en = 1'b1;
      OP_RRD:  begin rd_en = 1'b1; rd_addr = reg_addr; end
      OP_RWR:  begin wr_en = 1'b1; wr_addr = reg_addr; end
      OP_PUSH: begin wr_en = push_fire; wr_addr = push_addr; end
      OP_POP:  begin rd_en = pop_fire; rd_addr = pop_addr; end
      OP_BSET: begin bit_wr = 1'b1; bit_val = 1'b1; end
      OP_BCLR: bit_wr = 1'b1;
      OP_BRD:  bit_rd = 1'b1;
      default: ;
    endcase
  end

  rbs_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .bit_wr   (bit_wr),
    .bit_rd   (bit_rd),
    .bit_addr (bit_addr),
    .bit_idx  (bit_pos(addr_i)),
    .bit_val  (bit_val),
    .rd_data  (rdata_o),
    .rd_bit   (rbit_o)
  );

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_i,
  input logic [7:0] wdata_i,
  input logic [7:0] sp_o,
  input logic [1:0] bank_o,
  input logic       err_o,
  input logic       push_fire,
  input logic       pop_fire,
  input logic       fault_evt
);

  assert_push_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp_o == $past(sp_o) + 8'd1);

  assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> sp_o == $past(sp_o) - 8'd1);

  assert_sp_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd7) |=> sp_o == $past(wdata_i));

  assert_bank_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd11) |=> bank_o == $past(wdata_i[1:0]));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> err_o && $stable(sp_o));

  assert_push_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd5 && sp_o >= 8'h7F) |-> fault_evt && !push_fire);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 || op_i > 4'd11) |=> $stable(sp_o) && $stable(bank_o) && $stable(err_o));

endmodule

bind regbank_stack_ram rbs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_i      (op_i),
  .wdata_i   (wdata_i),
  .sp_o      (sp_o),
  .bank_o    (bank_o),
  .err_o     (err_o),
  .push_fire (push_fire),
  .pop_fire  (pop_fire),
  .fault_evt (fault_evt)
);

// File: tb/regbank_stack_ram_test.sv
`timescale 1ns/1ps
module regbank_stack_ram_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [6:0] addr_i = '0;
  logic [2:0] reg_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rbit_o;
  logic [7:0] sp_o;
  logic [1:0] bank_o;
  logic       err_o;

  regbank_stack_ram uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .reg_i(reg_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rbit_o(rbit_o), .sp_o(sp_o),
    .bank_o(bank_o), .err_o(err_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         kind;   // 0 rdata, 1 rbit, 2 sp, 3 bank, 4 err
    logic [7:0] val;
    string      tag;
    int         due;
  } item_t;

  item_t sb[$];
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Bench-side reference state
  logic [7:0] m_mem [128];
  logic [7:0] m_sp = 8'h07;
  logic [1:0] m_bank = 2'd0;
  logic       m_err = 1'b0;
  logic [7:0] m_rd = 8'h00;
  logic       m_bit = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] actual_of(int kind);
    case (kind)
      0: return rdata_o;
      1: return {7'd0, rbit_o};
      2: return sp_o;
      3: return {6'd0, bank_o};
      default: return {7'd0, err_o};
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compares scoreboard items once their cycle has come
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      check(actual_of(it.kind), it.val, it.tag);
    end
  end

  function automatic logic [6:0] win_byte(input logic [6:0] n);
    return 7'h20 | {4'd0, n[6:3]};
  endfunction

  // Driver: applies one operation and queues the expected outcome
  task automatic issue(input int op, input logic [6:0] a, input logic [2:0] r,
                       input logic [7:0] wd, input string tag);
    logic [6:0] loc;
    @(negedge clk);
    op_i = op[3:0]; addr_i = a; reg_i = r; wdata_i = wd;
    case (op)
      1: m_rd = m_mem[a];
      2: m_mem[a] = wd;
      3: m_rd = m_mem[{m_bank, r}];
      4: m_mem[{m_bank, r}] = wd;
      5: if (m_sp >= 8'h7F) m_err = 1'b1;
         else begin m_sp = m_sp + 8'd1; m_mem[m_sp[6:0]] = wd; end
      6: if (m_sp == 8'h00 || m_sp > 8'h7F) m_err = 1'b1;
         else begin m_rd = m_mem[m_sp[6:0]]; m_sp = m_sp - 8'd1; end
      7: m_sp = wd;
      8: begin loc = win_byte(a); m_mem[loc][a[2:0]] = 1'b1; end
      9: begin loc = win_byte(a); m_mem[loc][a[2:0]] = 1'b0; end
      10: begin loc = win_byte(a); m_bit = m_mem[loc][a[2:0]]; end
      11: m_bank = wd[1:0];
      default: ;
    endcase
    sb.push_back('{0, m_rd, {tag, " rdata"}, cyc + 1});
    sb.push_back('{1, {7'd0, m_bit}, {tag, " rbit"}, cyc + 1});
    sb.push_back('{2, m_sp, {tag, " sp"}, cyc + 1});
    sb.push_back('{3, {6'd0, m_bank}, {tag, " bank"}, cyc + 1});
    sb.push_back('{4, {7'd0, m_err}, {tag, " err"}, cyc + 1});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (whole run) actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sp_o, 8'h07, "R1 sp");
    check({6'd0, bank_o}, 8'h00, "R1 bank");
    check({7'd0, err_o}, 8'h00, "R1 err");
    check(rdata_o, 8'h00, "R1 rdata");
    check({7'd0, rbit_o}, 8'h00, "R1 rbit");
    rst_n = 1'b1;

    // R2: fill the whole RAM, read back a spread of addresses
    for (int i = 0; i < 128; i++) issue(2, 7'(i), 3'd0, 8'((i * 37 + 11) & 8'hFF), "R2");
    issue(1, 7'h00, 3'd0, 8'h00, "R2");
    issue(1, 7'h7F, 3'd0, 8'h00, "R2");
    issue(1, 7'h45, 3'd0, 8'h00, "R2");
    // R11: non-read operations keep rdata
    issue(2, 7'h50, 3'd0, 8'hC3, "R11");
    issue(1, 7'h50, 3'd0, 8'h00, "R2");

    // R3: banked register access
    issue(11, 7'h00, 3'd0, 8'h02, "R3");
    issue(4, 7'h00, 3'd3, 8'h9A, "R3");
    issue(1, 7'h13, 3'd0, 8'h00, "R3");
    issue(11, 7'h00, 3'd0, 8'h03, "R3");
    issue(4, 7'h00, 3'd7, 8'h5E, "R3");
    issue(3, 7'h00, 3'd7, 8'h00, "R3");
    issue(1, 7'h1F, 3'd0, 8'h00, "R3");
    issue(11, 7'h00, 3'd0, 8'h00, "R3");
    issue(3, 7'h00, 3'd2, 8'h00, "R3");
    issue(11, 7'h00, 3'd0, 8'h01, "R3");
    issue(3, 7'h00, 3'd0, 8'h00, "R3");

    // R4 and R5: push, then pop in reverse order
    issue(5, 7'h00, 3'd0, 8'h25, "R4");
    issue(5, 7'h00, 3'd0, 8'h12, "R4");
    issue(1, 7'h08, 3'd0, 8'h00, "R4");
    issue(1, 7'h09, 3'd0, 8'h00, "R4");
    issue(6, 7'h00, 3'd0, 8'h00, "R5");
    issue(6, 7'h00, 3'd0, 8'h00, "R5");

    // R6: move the stack above the bit window
    issue(7, 7'h00, 3'd0, 8'h2F, "R6");
    issue(5, 7'h00, 3'd0, 8'hE1, "R6");
    issue(1, 7'h30, 3'd0, 8'h00, "R6");
    issue(6, 7'h00, 3'd0, 8'h00, "R6");

    // R7 and R8: bit window, first and last bit addresses
    issue(8, 7'h0B, 3'd0, 8'h00, "R7");
    issue(1, 7'h21, 3'd0, 8'h00, "R7");
    issue(9, 7'h7F, 3'd0, 8'h00, "R7");
    issue(1, 7'h2F, 3'd0, 8'h00, "R7");
    issue(9, 7'h00, 3'd0, 8'h00, "R7");
    issue(8, 7'h01, 3'd0, 8'h00, "R7");
    issue(1, 7'h20, 3'd0, 8'h00, "R7");
    issue(10, 7'h0B, 3'd0, 8'h00, "R8");
    issue(10, 7'h7F, 3'd0, 8'h00, "R8");
    issue(10, 7'h01, 3'd0, 8'h00, "R8");
    issue(10, 7'h00, 3'd0, 8'h00, "R8");

    // R10: idle and unused codes
    issue(0, 7'h12, 3'd1, 8'hFF, "R10");
    issue(12, 7'h12, 3'd1, 8'hFF, "R10");
    issue(15, 7'h12, 3'd1, 8'hFF, "R10");
    issue(1, 7'h12, 3'd0, 8'h00, "R10");

    // R9: pop from 00H refused, rdata and memory unchanged
    issue(1, 7'h05, 3'd0, 8'h00, "R9");
    issue(7, 7'h00, 3'd0, 8'h00, "R9");
    issue(6, 7'h00, 3'd0, 8'h00, "R9");
    issue(1, 7'h00, 3'd0, 8'h00, "R9");
    // R9: push at 7FH refused, top byte unchanged, flag stays set
    issue(7, 7'h00, 3'd0, 8'h7F, "R9");
    issue(5, 7'h00, 3'd0, 8'hAA, "R9");
    issue(1, 7'h7F, 3'd0, 8'h00, "R9");
    issue(1, 7'h00, 3'd0, 8'h00, "R9");
    // R9: pop while pointer is above 7FH refused
    issue(7, 7'h00, 3'd0, 8'h90, "R9");
    issue(6, 7'h00, 3'd0, 8'h00, "R9");
    issue(0, 7'h00, 3'd0, 8'h00, "R9");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule